// File: doc/BRIEF.md
# Self-Correcting Six-State Counter

This block is a 3-bit synchronous counter whose state bits each behave like a JK flip-flop. The bits are named A (most significant, `stateOut[2]`), B (`stateOut[1]`) and C (`stateOut[0]`). Their excitation is fixed: A has J = B and K = B, B has J = C and K = 1, and C has J = not B and K = 1. Counting with these equations gives a repeating cycle of six codes. Codes 011 and 111 are not part of that cycle.

The two unused codes are not treated as don't-cares. The same equations are applied to them, and each one returns to the main cycle after a single counting clock. A parallel load port can force any 3-bit code, including the unused ones, so the recovery paths can be exercised directly.

The counter advances only when the count enable is high. A synchronous reset has the highest priority, load comes next, and counting has the lowest priority.

Top module: `jk_six_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `stateOut` becomes 000 after that edge, whatever `ldEn`, `ldVal` and `cntEn` are.
- R2: With `rst` = 0, `ldEn` = 0 and `cntEn` = 1, each clock edge moves `stateOut` (bit 2 = A, bit 1 = B, bit 0 = C) along the cycle 000, 001, 010, 100, 101, 110, and then back to 000.
- R3: With `rst` = 0, `ldEn` = 0 and `cntEn` = 0, a clock edge leaves `stateOut` unchanged, for every one of the eight codes.
- R4: With `rst` = 0 and `ldEn` = 1, a clock edge sets `stateOut` to `ldVal`, for all eight codes, even when `cntEn` is 1.
- R5: An enabled count from the unused code 011 gives 100.
- R6: An enabled count from the unused code 111 gives 000.
- R7: An enabled count from any of the six cycle codes never gives 011 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, forces 000 |
| cntEn | input | 1 | Count enable, active high |
| ldEn | input | 1 | Parallel load strobe, active high |
| ldVal | input | 3 | Code to load (bit 2 = A) |
| stateOut | output | 3 | Counter state: A, B, C from MSB to LSB |

## Verification
The assertions assume that every control input has a known value at each rising edge after reset, and that `ldVal` is stable at the edge where `ldEn` is high. The bench changes all inputs only on the falling clock edge, so each control has half a period to settle before the next rising edge.

Every starting code, including 011 and 111, is reached through the load port. From each code the bench applies an enabled count, a hold and a load. It then runs long counting stretches and compares each state against an expected cycle computed from its position in the sequence.

// File: rtl/jk_six_pkg.sv
package jk_six_pkg;
  localparam int STATE_W = 3;
  localparam int CYCLE_LEN = 6;

  typedef logic [STATE_W-1:0] stateT;

  typedef struct packed {
    logic clr;
    logic load;
    logic step;
  } strobeT;
endpackage

// File: rtl/jk_six_ctrl.sv
module jk_six_ctrl
  import jk_six_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cntEn,
  input  logic   ldEn,
  output strobeT strobes
);
  // Priority decode: reset over load over count.
  always_comb begin
    strobes.clr  = rst;
    strobes.load = !rst && ldEn;
    strobes.step = !rst && !ldEn && cntEn;
  end

  // R4: load wins over count.
  p_load_beats_count_r4: assert property (@(posedge clk) disable iff (rst)
    (ldEn && cntEn) |-> (strobes.load && !strobes.step));

  // R1: reset wins over everything.
  p_reset_first_r1: assert property (@(posedge clk)
    rst |-> (strobes.clr && !strobes.load && !strobes.step));
endmodule

// File: rtl/jk_cell.sv
module jk_cell (
  input  logic clk,
  input  logic clr,
  input  logic load,
  input  logic ldBit,
  input  logic step,
  input  logic jIn,
  input  logic kIn,
  output logic qOut
);
  logic jkNext;

  // JK behaviour: set, reset, toggle or keep.
  always_comb begin
    unique case ({jIn, kIn})
      2'b00:   jkNext = qOut;
      2'b01:   jkNext = 1'b0;
      2'b10:   jkNext = 1'b1;
      default: jkNext = !qOut;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr)       qOut <= 1'b0;
    else if (load) qOut <= ldBit;
    else if (step) qOut <= jkNext;
  end
endmodule

// File: rtl/jk_six_dpath.sv
module jk_six_dpath
  import jk_six_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  strobeT strobes,
  input  stateT  ldVal,
  output stateT  stateQ
);
  localparam int BIT_A = STATE_W - 1;
  localparam int BIT_B = STATE_W - 2;
  localparam int BIT_C = STATE_W - 3;

  logic bitA, bitB, bitC;
  stateT jVec, kVec;

  assign bitA = stateQ[BIT_A];
  assign bitB = stateQ[BIT_B];
  assign bitC = stateQ[BIT_C];

  // Fixed excitation network.
  always_comb begin
    jVec[BIT_A] = bitB;
    kVec[BIT_A] = bitB;
    jVec[BIT_B] = bitC;
    kVec[BIT_B] = 1'b1;
    jVec[BIT_C] = !bitB;
    kVec[BIT_C] = 1'b1;
  end

  for (genvar i = 0; i < STATE_W; i++) begin : g_cell
    jk_cell u_cell (
      .clk  (clk),
      .clr  (strobes.clr),
      .load (strobes.load),
      .ldBit(ldVal[i]),
      .step (strobes.step),
      .jIn  (jVec[i]),
      .kIn  (kVec[i]),
      .qOut (stateQ[i])
    );
  end

  // R1
  p_reset_zero_r1: assert property (@(posedge clk)
    strobes.clr |=> (stateQ == 3'b000));

  // R3
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobes.clr && !strobes.load && !strobes.step) |=> $stable(stateQ));

  // R4
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (stateQ == $past(ldVal)));

  // R2: wrap from the last cycle code.
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && stateQ == 3'b110) |=> (stateQ == 3'b000));

  // R5
  p_recover_011_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && stateQ == 3'b011) |=> (stateQ == 3'b100));

  // R6
  p_recover_111_r6: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && stateQ == 3'b111) |=> (stateQ == 3'b000));

  // R7
  p_stay_in_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && stateQ != 3'b011 && stateQ != 3'b111)
      |=> (stateQ != 3'b011 && stateQ != 3'b111));
endmodule

// File: rtl/jk_six_counter.sv
module jk_six_counter
  import jk_six_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cntEn,
  input  logic               ldEn,
  input  logic [STATE_W-1:0] ldVal,
  output logic [STATE_W-1:0] stateOut
);
  strobeT strobes;

  jk_six_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .cntEn  (cntEn),
    .ldEn   (ldEn),
    .strobes(strobes)
  );

  jk_six_dpath u_dpath (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .ldVal  (ldVal),
    .stateQ (stateOut)
  );
endmodule

// File: tb/sim_jk_six_counter.sv
module sim_jk_six_counter;
  logic clk = 1'b0;
  logic rst, cntEn, ldEn;
  logic [2:0] ldVal;
  logic [2:0] stateOut;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = !clk;

  jk_six_counter u0 (
    .clk(clk), .rst(rst), .cntEn(cntEn), .ldEn(ldEn),
    .ldVal(ldVal), .stateOut(stateOut)
  );

  // Cycle order taken from R2, indexed by position.
  function automatic logic [2:0] cycleCode(int idx);
    case (idx % 6)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b010;
      3: return 3'b100;
      4: return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  // Expected next code for an enabled count (R2, R5, R6).
  function automatic logic [2:0] expNext(logic [2:0] cur);
    if (cur == 3'b011) return 3'b100;
    if (cur == 3'b111) return 3'b000;
    for (int i = 0; i < 6; i++)
      if (cycleCode(i) == cur) return cycleCode(i + 1);
    return 3'bxxx;
  endfunction

  task automatic check(string req, logic [2:0] exp);
    nChecks++;
    if (stateOut !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, stateOut, exp);
    end
  endtask

  // Called at a falling edge; drives, crosses one rising edge, returns at next falling edge.
  task automatic cyc(logic r, logic l, logic [2:0] v, logic e);
    rst = r; ldEn = l; ldVal = v; cntEn = e;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; ldEn = 1'b1; ldVal = 3'b101; cntEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", 3'b000);

    for (int s = 0; s < 8; s++) begin
      cyc(0, 1, 3'(s), 0);
      check("R4 load", 3'(s));
      cyc(0, 0, 3'(~s), 0);
      check("R3 hold", 3'(s));
      cyc(0, 0, 3'(~s), 1);
      if (s == 3)      check("R5 recover 011", 3'b100);
      else if (s == 7) check("R6 recover 111", 3'b000);
      else begin
        check("R2 step", expNext(3'(s)));
        nChecks++;
        if (stateOut == 3'b011 || stateOut == 3'b111) begin
          nFails++;
          $display("FAIL R7: got %b expected a cycle code", stateOut);
        end
      end
      cyc(0, 1, 3'(~s), 1);
      check("R4 load over count", 3'(~s));
      cyc(1, 1, 3'(s), 1);
      check("R1 reset over load", 3'b000);
    end

    cyc(1, 0, 3'b000, 0);
    for (int n = 1; n <= 30; n++) begin
      cyc(0, 0, 3'b111, 1);
      check("R2 long run", cycleCode(n));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule